// File: doc/BRIEF.md
# Keyed Nonvolatile Word Write Controller

This block guards single-word erase and program operations on a word-organised nonvolatile data array. A processor reaches it through a small register bus: a control register, an address register, a write-only key register, and a read-only view of a data latch. The data latch is loaded by a separate table-style write access, which also captures the target address. A cycle starts only after an exact two-value unlock sequence has been written to the key register, with write enable already set by an earlier write. The request to start must be the very next bus write.

Once a cycle starts, the controller captures the operation, address and data. It counts out a fixed cycle time while the bus stays fully usable. At the end it updates the array, clears its start bit and raises a sticky completion flag. An optional interrupt output follows that flag. The array is a behavioural memory. An erase sets a word to all ones. A program ANDs the latch value into the old word, so programming a word that was not erased leaves a visibly corrupted value.

Top module: `nvw_ctrl`

## Requirements
- R1: A cycle starts only when the key register (select 2) receives 0x0055 and then 0x00AA, and the very next bus write is a control write (select 0) with GO (bit 0) set.
- R2: A wrong key value, a 0x00AA without a preceding 0x0055, or a write to any other register between the two keys returns the unlock state to idle. Any bus write after the second key uses up the unlock, so every cycle needs a fresh sequence.
- R3: GO takes effect only if write enable (control bit 1) was already 1 before that write. A single write that sets both bits starts nothing.
- R4: Hardware never changes write enable. Clearing it during a cycle neither aborts nor alters that cycle.
- R5: At the end of a cycle, GO reads 0 and the done flag (control bit 3) reads 1. Done stays set until a control write puts 0 in bit 3, and writing 1 there has no effect.
- R6: GO reads 1 for exactly CYCLE_CLKS clock cycles. Register writes made during the cycle take effect at once.
- R7: Control bit 2 selects the operation: 0 erases, writing all ones to the word; 1 programs, storing the old word ANDed with the latch.
- R8: A table write loads the latch (readable at select 3) and copies its address into the address register (select 1). The key register reads 0.
- R9: irq is high exactly while done and interrupt enable (control bit 4) are both 1.
- R10: Operation, address and data are frozen when a cycle starts. Later writes to the control register, address register or latch do not alter the word that cycle writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_sel | input | 2 | Write register select: 0 control, 1 address, 2 key, 3 latch (read-only) |
| bus_wdata | input | DW | Register write data |
| bus_rsel | input | 2 | Read register select |
| bus_rdata | output | DW | Read data for bus_rsel |
| tbl_we | input | 1 | Table write strobe: loads latch and address |
| tbl_addr | input | AW | Table write word address |
| tbl_wdata | input | DW | Table write data |
| peek_addr | input | AW | Array observation address |
| peek_data | output | DW | Array word at peek_addr |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions check on every cycle the following:
- a cycle only begins from the armed unlock state with write enable set beforehand;
- the armed state never survives a bus write;
- write enable changes only under a control write;
- busy holds while the counter is nonzero;
- the captured operands stay frozen;
- a finishing cycle always sets done, and done stays set until cleared.

Other behaviours show only in the bench's scenarios:
- the exact busy length;
- the array contents after erase and program, including a program applied to a word that was not erased;
- rejected start requests, seen as the absence of any effect;
- the interrupt gating.

// File: rtl/nvw_pkg.sv
package nvw_pkg;
  localparam logic [1:0] SEL_CTRL  = 2'd0;
  localparam logic [1:0] SEL_ADDR  = 2'd1;
  localparam logic [1:0] SEL_KEY   = 2'd2;
  localparam logic [1:0] SEL_LATCH = 2'd3;

  localparam int B_GO   = 0;
  localparam int B_WEN  = 1;
  localparam int B_OP   = 2;
  localparam int B_DONE = 3;
  localparam int B_IE   = 4;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;

  typedef enum logic [1:0] {
    UNLK_IDLE  = 2'd0,
    UNLK_HALF  = 2'd1,
    UNLK_ARMED = 2'd2
  } unlk_e;
endpackage

// File: rtl/nvw_key_fsm.sv
module nvw_key_fsm
  import nvw_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [1:0]    bus_sel,
  input  logic [DW-1:0] bus_wdata,
  output logic          armed
);
  unlk_e st;
  logic  key_wr, is_first, is_second;

  assign key_wr    = bus_we && (bus_sel == SEL_KEY);
  assign is_first  = key_wr && (bus_wdata == DW'(KEY_FIRST));
  assign is_second = key_wr && (bus_wdata == DW'(KEY_SECOND));
  assign armed     = (st == UNLK_ARMED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= UNLK_IDLE;
    else if (bus_we) begin
      unique case (st)
        UNLK_IDLE: st <= is_first ? UNLK_HALF : UNLK_IDLE;
        UNLK_HALF: st <= is_second ? UNLK_ARMED : UNLK_IDLE;
        default:   st <= UNLK_IDLE;
      endcase
    end
  end

  // R2: an armed unlock never outlives the next bus write
  assert_key_consumed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    armed && bus_we |=> !armed);
  // R1: arming only follows the second key value
  assert_arm_needs_second_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(is_second));
endmodule

// File: rtl/nvw_timer.sv
module nvw_timer #(
  parameter int AW         = 8,
  parameter int DW         = 16,
  parameter int CYCLE_CLKS = 100000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_in,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  output logic          busy,
  output logic          fin,
  output logic          op_l,
  output logic [AW-1:0] addr_l,
  output logic [DW-1:0] data_l
);
  localparam int CW = $clog2(CYCLE_CLKS + 1);
  logic [CW-1:0] cnt;

  assign fin = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      op_l   <= 1'b0;
      addr_l <= '0;
      data_l <= '0;
    end else if (start && !busy) begin
      busy   <= 1'b1;
      cnt    <= CW'(CYCLE_CLKS - 1);
      op_l   <= op_in;
      addr_l <= addr_in;
      data_l <= data_in;
    end else if (busy) begin
      if (fin) busy <= 1'b0;
      else     cnt  <= cnt - 1'b1;
    end
  end

  // R6: the cycle cannot end while time remains
  assert_cycle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (cnt != '0) |=> busy);
  // R10: captured operands stay frozen for the whole cycle
  assert_operands_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !fin |=> $stable(op_l) && $stable(addr_l) && $stable(data_l));
endmodule

// File: rtl/nvw_array.sv
module nvw_array #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit,
  input  logic          op,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  input  logic [AW-1:0] peek_addr,
  output logic [DW-1:0] peek_data
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  function automatic logic [DW-1:0] next_word(input logic prog,
                                              input logic [DW-1:0] old,
                                              input logic [DW-1:0] lat);
    return prog ? (old & lat) : {DW{1'b1}};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= {DW{1'b1}};
    end else if (commit) begin
      mem[addr] <= next_word(op, mem[addr], data);
    end
  end

  assign peek_data = mem[peek_addr];
endmodule

// File: rtl/nvw_ctrl.sv
module nvw_ctrl
  import nvw_pkg::*;
#(
  parameter int AW         = 8,
  parameter int DW         = 16,
  parameter int CYCLE_CLKS = 100000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [1:0]    bus_sel,
  input  logic [DW-1:0] bus_wdata,
  input  logic [1:0]    bus_rsel,
  output logic [DW-1:0] bus_rdata,
  input  logic          tbl_we,
  input  logic [AW-1:0] tbl_addr,
  input  logic [DW-1:0] tbl_wdata,
  input  logic [AW-1:0] peek_addr,
  output logic [DW-1:0] peek_data,
  output logic          irq
);
  logic          wen_q, op_q, ie_q, done_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] latch_q;
  logic          armed, busy, fin, c_op;
  logic [AW-1:0] c_addr;
  logic [DW-1:0] c_data;
  logic          ctrl_wr, start_ok, done_clr;

  assign ctrl_wr  = bus_we && (bus_sel == SEL_CTRL);
  assign start_ok = ctrl_wr && bus_wdata[B_GO] && armed && wen_q && !busy;
  assign done_clr = ctrl_wr && !bus_wdata[B_DONE];

  nvw_key_fsm #(.DW(DW)) u_key (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .armed(armed)
  );

  nvw_timer #(.AW(AW), .DW(DW), .CYCLE_CLKS(CYCLE_CLKS)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(start_ok), .op_in(bus_wdata[B_OP]),
    .addr_in(addr_q), .data_in(latch_q), .busy(busy), .fin(fin),
    .op_l(c_op), .addr_l(c_addr), .data_l(c_data)
  );

  nvw_array #(.AW(AW), .DW(DW)) u_arr (
    .clk(clk), .rst_n(rst_n), .commit(fin), .op(c_op), .addr(c_addr),
    .data(c_data), .peek_addr(peek_addr), .peek_data(peek_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wen_q   <= 1'b0;
      op_q    <= 1'b0;
      ie_q    <= 1'b0;
      done_q  <= 1'b0;
      addr_q  <= '0;
      latch_q <= '0;
    end else begin
      if (ctrl_wr) begin
        wen_q <= bus_wdata[B_WEN];
        op_q  <= bus_wdata[B_OP];
        ie_q  <= bus_wdata[B_IE];
      end
      if (fin)           done_q <= 1'b1;
      else if (done_clr) done_q <= 1'b0;
      if (tbl_we) begin
        addr_q  <= tbl_addr;
        latch_q <= tbl_wdata;
      end else if (bus_we && bus_sel == SEL_ADDR) begin
        addr_q  <= bus_wdata[AW-1:0];
      end
    end
  end

  always_comb begin
    unique case (bus_rsel)
      SEL_CTRL:  bus_rdata = DW'({ie_q, done_q, op_q, wen_q, busy});
      SEL_ADDR:  bus_rdata = DW'(addr_q);
      SEL_KEY:   bus_rdata = '0;
      default:   bus_rdata = latch_q;
    endcase
  end

  assign irq = done_q && ie_q;

  // R1: a cycle only begins from the armed unlock state
  assert_start_needs_key_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(armed));
  // R3: write enable must already be set when GO arrives
  assert_start_needs_wen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wen_q));
  // R4: hardware never touches write enable
  assert_wen_sw_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(wen_q));
  // R5: a finishing cycle leaves done set and GO clear
  assert_done_on_finish_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> done_q && !busy);
  // R5: done is sticky until software clears it
  assert_done_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && !done_clr |=> done_q);
endmodule

// File: tb/nvw_ctrl_bench.sv
module nvw_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int N  = 40;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [1:0] bus_sel = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [1:0] bus_rsel = '0;
  logic [DW-1:0] bus_rdata;
  logic tbl_we = 1'b0;
  logic [AW-1:0] tbl_addr = '0;
  logic [DW-1:0] tbl_wdata = '0;
  logic [AW-1:0] peek_addr = '0;
  logic [DW-1:0] peek_data;
  logic irq;

  int checks = 0;
  int fails = 0;
  logic [DW-1:0] model [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  nvw_ctrl #(.AW(AW), .DW(DW), .CYCLE_CLKS(N)) u_nvw_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rsel(bus_rsel), .bus_rdata(bus_rdata),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
    .peek_addr(peek_addr), .peek_data(peek_data), .irq(irq)
  );

  // control word encoding: GO bit0, WEN bit1, OP bit2 (1 program), DONE bit3, IE bit4
  function automatic logic [DW-1:0] ctl(input logic go, input logic wen,
                                        input logic op, input logic dn,
                                        input logic ie);
    return DW'({ie, dn, op, wen, go});
  endfunction

  function automatic logic [DW-1:0] expect_word(input logic prog,
                                                input logic [DW-1:0] old,
                                                input logic [DW-1:0] lat);
    logic [DW-1:0] r;
    for (int b = 0; b < DW; b++) r[b] = prog ? (old[b] && lat[b]) : 1'b1;
    return r;
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bw(input logic [1:0] s, input logic [DW-1:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_sel = s; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic tw(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = a; tbl_wdata = d;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [DW-1:0] v);
    bus_rsel = s;
    #1;
    v = bus_rdata;
  endtask

  task automatic peek(input logic [AW-1:0] a, output logic [DW-1:0] v);
    peek_addr = a;
    #1;
    v = peek_data;
  endtask

  // full sequence; returns number of clocks GO read 1
  task automatic run_cycle(input logic op, output int n);
    logic [DW-1:0] v;
    bw(2'd0, ctl(0, 1, op, 0, 0));
    bw(2'd2, 16'h0055);
    bw(2'd2, 16'h00AA);
    bw(2'd0, ctl(1, 1, op, 0, 0));
    n = 0;
    rd(2'd0, v);
    while (v[0] && n < 10 * N) begin
      n++;
      @(negedge clk);
      rd(2'd0, v);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    logic [DW-1:0] w;
    int n;
    void'($urandom(32'd1234));
    for (int i = 0; i < DEPTH; i++) model[i] = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    rd(2'd0, v); check(v == '0, "R5 reset ctrl", v, '0);
    check(irq == 1'b0, "R9 reset irq", DW'(irq), '0);
    peek(4'd9, v); check(v == '1, "R7 reset array", v, '1);

    // R8 table write
    tw(4'd5, 16'h1234);
    rd(2'd1, v); check(v == 16'd5, "R8 addr capture", v, 16'd5);
    rd(2'd3, v); check(v == 16'h1234, "R8 latch load", v, 16'h1234);
    bw(2'd2, 16'h0055);
    rd(2'd2, v); check(v == '0, "R8 key reads zero", v, '0);
    bw(2'd2, 16'h0000);

    // R3: WEN and GO set together after keys
    bw(2'd2, 16'h0055); bw(2'd2, 16'h00AA);
    bw(2'd0, ctl(1, 1, 1, 0, 0));
    rd(2'd0, v); check(v[0] == 1'b0, "R3 wen and go together", v, ctl(0, 1, 1, 0, 0));

    // R1: no keys at all
    bw(2'd0, ctl(1, 1, 1, 0, 0));
    rd(2'd0, v); check(v[0] == 1'b0, "R1 go without keys", v, ctl(0, 1, 1, 0, 0));

    // R2: other register written between keys
    bw(2'd2, 16'h0055); bw(2'd1, 16'd5); bw(2'd2, 16'h00AA);
    bw(2'd0, ctl(1, 1, 1, 0, 0));
    rd(2'd0, v); check(v[0] == 1'b0, "R2 write between keys", v, ctl(0, 1, 1, 0, 0));
    // R2: keys in reverse order
    bw(2'd2, 16'h00AA); bw(2'd2, 16'h0055);
    bw(2'd0, ctl(1, 1, 1, 0, 0));
    rd(2'd0, v); check(v[0] == 1'b0, "R2 reversed keys", v, ctl(0, 1, 1, 0, 0));
    // R2: wrong second value
    bw(2'd2, 16'h0055); bw(2'd2, 16'h00AB);
    bw(2'd0, ctl(1, 1, 1, 0, 0));
    rd(2'd0, v); check(v[0] == 1'b0, "R2 wrong key value", v, ctl(0, 1, 1, 0, 0));
    peek(4'd5, v); check(v == '1, "R1 rejected starts leave array", v, '1);

    // proper program of erased word
    tw(4'd5, 16'h1234);
    run_cycle(1'b1, n);
    check(n == N, "R6 busy length", DW'(n), DW'(N));
    model[5] = expect_word(1'b1, model[5], 16'h1234);
    peek(4'd5, v); check(v == model[5], "R7 program erased word", v, model[5]);
    rd(2'd0, v); check(v == ctl(0, 1, 1, 1, 0), "R5 go clear done set", v, ctl(0, 1, 1, 1, 0));
    check(v[1] == 1'b1, "R4 wen kept after cycle", v, ctl(0, 1, 1, 1, 0));

    // R2: unlock consumed by the previous cycle
    bw(2'd0, ctl(1, 1, 1, 1, 0));
    rd(2'd0, v); check(v[0] == 1'b0, "R2 key reused", v, ctl(0, 1, 1, 1, 0));

    // R5 sticky done, R9 irq
    bw(2'd0, ctl(0, 1, 0, 1, 1));
    rd(2'd0, v); check(v[3] == 1'b1, "R5 write one keeps done", v, ctl(0, 1, 0, 1, 1));
    check(irq == 1'b1, "R9 irq with done and ie", DW'(irq), 16'd1);
    bw(2'd0, ctl(0, 1, 0, 0, 1));
    rd(2'd0, v); check(v[3] == 1'b0, "R5 write zero clears done", v, ctl(0, 1, 0, 0, 1));
    check(irq == 1'b0, "R9 irq drops with done", DW'(irq), 16'd0);
    bw(2'd0, ctl(0, 1, 0, 0, 0));

    // R4/R10: erase addr 5 while disturbing registers mid-cycle
    bw(2'd1, 16'd5);
    bw(2'd2, 16'h0055); bw(2'd2, 16'h00AA);
    bw(2'd0, ctl(1, 1, 0, 0, 0));
    bw(2'd0, ctl(0, 0, 1, 0, 0));
    bw(2'd1, 16'd6);
    tw(4'd7, 16'h0000);
    rd(2'd0, v); check(v[0] == 1'b1, "R4 wen clear does not abort", v, ctl(1, 0, 1, 0, 0));
    rd(2'd1, v); check(v == 16'd7, "R6 bus writes during cycle", v, 16'd7);
    rd(2'd0, v);
    while (v[0]) begin @(negedge clk); rd(2'd0, v); end
    model[5] = '1;
    peek(4'd5, v); check(v == '1, "R10 erase kept captured addr", v, 16'hFFFF);
    peek(4'd6, v); check(v == model[6], "R10 addr 6 untouched", v, model[6]);
    peek(4'd7, v); check(v == model[7], "R10 addr 7 untouched", v, model[7]);
    rd(2'd0, v); check(v[1] == 1'b0 && v[3], "R4 wen stays clear", v, ctl(0, 0, 1, 1, 0));

    // random erase/program mix, including program without erase (R7)
    for (int k = 0; k < 16; k++) begin
      logic [AW-1:0] a;
      logic op;
      a = AW'($urandom % DEPTH);
      op = 1'($urandom % 2);
      w = DW'($urandom);
      if (k == 0) begin a = 4'd5; op = 1'b1; w = 16'h0F0F; end
      if (k == 1) begin a = 4'd5; op = 1'b1; w = 16'h33FF; end
      if (op) tw(a, w); else bw(2'd1, DW'(a));
      run_cycle(op, n);
      check(n == N, "R6 busy length random", DW'(n), DW'(N));
      model[a] = expect_word(op, model[a], w);
      peek(a, v); check(v == model[a], "R7 random op result", v, model[a]);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule